// File: doc/BRIEF.md
# Cell-Addressed I/O Region Bridge

This block sits between the core of a one-instruction processor and everything that core can reach through memory. The core presents a signed cell address and a read or write strobe, and the bridge decides which region the cell belongs to. The regions are the program space, the display parameter cells, the pixel store, the block-transfer registers, the timer vectors, the serial port selector and the single streaming data cell. It reports the region as a one-hot select and gives the cell's offset inside that region. Program, pixel, block and timer cells live in storage outside the bridge and are reached through a plain external port.

Two cells at the very top of the address space are handled inside the bridge. Cell -2 holds the number of the byte-stream port in use, where zero means the console. Cell -1 is the streaming data cell. A read of it asks the stream side for one cell of input and holds the core with a low ready until that cell arrives. A write of it hands one cell to the stream side and holds the core until the stream side acknowledges it. The display geometry (width, height and cells per pixel) is fixed at elaboration and reads back as constants. The positions of the block registers and of the unused gap are derived from that geometry.

Top module: `mmio_bridge`

## Requirements
- R1: With the default geometry (width 8, height 4, 2 cells per pixel, 2 timers, 16-bit addresses), addresses 0 to 32767 select the program region (select bit 0). The offset equals the address, external strobes follow the core strobes, and read data comes from `ext_rdata`.
- R2: Cells -32768, -32767 and -32766 (select bit 1) read back the width, height and cells-per-pixel parameters at offsets 0, 1 and 2. Writes to them raise no external strobe and leave the read values unchanged.
- R3: The pixel region (select bit 2) starts at cell -32765 and is width*height*depth cells long, which is -32765 to -32702 by default. The offset is counted from its first cell, and accesses go to the external port.
- R4: The block-transfer region (select bit 3) consists of the four cells that follow the pixel region: port, length, buffer address and trigger, at offsets 0 to 3. By default these are cells -32701 to -32698, and accesses go to the external port.
- R5: The timer region (select bit 4) covers the 3*T cells that end at cell -3, which is -8 to -3 by default. Offsets are counted from its lowest cell, and accesses go to the external port.
- R6: Cells between the block region and the timer region (select bit 7) read as 0. Writes to them raise no external strobe.
- R7: Cell -2 (select bit 5) holds the stream port number. It reads 0 after reset and reads back the last value written, which is also driven on `io_port`.
- R8: A read of cell -1 (select bit 6) raises `in_req` for exactly one cycle, in the cycle after the read is presented. `cpu_ready` stays low until `in_valid` is seen, and `cpu_rdata` then equals `in_data` in that cycle. `in_valid` counts from the `in_req` cycle onward.
- R9: A write of cell -1 raises `out_req` for exactly one cycle, in the cycle after the write is presented, with `out_data` equal to the written value. `cpu_ready` stays low until `out_ack` is seen, counting from the `out_req` cycle onward.
- R10: Exactly one select bit is set for every address. Any access outside cell -1 completes with `cpu_ready` high in the cycle it is presented.
- R11: Each access to cell -1 moves exactly one cell. No second request is raised while a transfer is waiting, and `in_req` and `out_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Signed cell address from the core |
| cpu_rd | input | 1 | Read strobe, held until ready |
| cpu_wr | input | 1 | Write strobe, held until ready |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data |
| cpu_ready | output | 1 | Access completes at the edge where this is high |
| rgn_sel | output | 8 | One-hot region select |
| rgn_off | output | 16 | Cell offset inside the region |
| ext_rd | output | 1 | Read strobe to external storage |
| ext_wr | output | 1 | Write strobe to external storage |
| ext_wdata | output | 16 | Write data to external storage |
| ext_rdata | input | 16 | Same-cycle read data from external storage |
| in_req | output | 1 | One-cycle request for one input cell |
| in_valid | input | 1 | Input cell is present on in_data |
| in_data | input | 16 | Input cell |
| out_req | output | 1 | One-cycle request to send one cell |
| out_data | output | 16 | Cell being sent |
| out_ack | input | 1 | Stream side has taken the cell |
| io_port | output | 16 | Selected stream port number |

## Verification
The bench probes the edges of every region: the first and last program cell, both ends of the pixel store, all four block cells, the two ends of the gap and both ends of the timer area. An off-by-one in the derived bases would show up there as a wrong select bit or a shifted offset. The bench writes to the parameter cells and to the gap. A decoder that forwards those writes would raise an external strobe, and one that stores them would change the values read back. Stream transfers are run with the answer arriving in the request cycle and with the answer arriving several cycles later. A design that repeats requests, releases the core too early or returns stale input fails those runs, and so does a design that ignores the port number written to cell -2.

// File: rtl/mmio_pkg.sv
package mmio_pkg;

  localparam int RGN_N      = 8;
  localparam int RG_PROG    = 0;
  localparam int RG_VPARAM  = 1;
  localparam int RG_VRAM    = 2;
  localparam int RG_BLOCK   = 3;
  localparam int RG_TIMER   = 4;
  localparam int RG_PORT    = 5;
  localparam int RG_DATA    = 6;
  localparam int RG_UNUSED  = 7;

  typedef enum logic [1:0] {
    SC_IDLE     = 2'd0,
    SC_WAIT_IN  = 2'd1,
    SC_WAIT_OUT = 2'd2
  } stream_st_t;

  // First (lowest) cell of the upper half of a space of 2**aw cells.
  function automatic int param_lo(input int aw);
    return -(2 ** (aw - 1));
  endfunction

  function automatic int vram_lo(input int aw);
    return param_lo(aw) + 3;
  endfunction

  function automatic int vram_cells(input int w, input int h, input int c);
    return w * h * c;
  endfunction

  function automatic int block_lo(input int aw, input int w, input int h, input int c);
    return vram_lo(aw) + vram_cells(w, h, c);
  endfunction

  // port, length, buffer address (s cells), trigger
  function automatic int block_cells(input int s);
    return 3 + s;
  endfunction

  function automatic int timer_cells(input int s, input int t);
    return (s + 2) * t;
  endfunction

  // Lowest timer cell; the area ends at cell -3.
  function automatic int timer_lo(input int s, input int t);
    return -2 - timer_cells(s, t);
  endfunction

endpackage

// File: rtl/mmio_region_decode.sv
module mmio_region_decode
  import mmio_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int VID_W  = 8,
  parameter int VID_H  = 4,
  parameter int VID_C  = 2,
  parameter int PTR_S  = 1,
  parameter int TIMERS = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [RGN_N-1:0]  sel,
  output logic [ADDR_W-1:0] off
);

  localparam int PLO = param_lo(ADDR_W);
  localparam int VLO = vram_lo(ADDR_W);
  localparam int BLO = block_lo(ADDR_W, VID_W, VID_H, VID_C);
  localparam int BHI = BLO + block_cells(PTR_S) - 1;
  localparam int TLO = timer_lo(PTR_S, TIMERS);

  int a;

  always_comb begin
    a   = int'($signed(addr));
    sel = '0;
    off = '0;
    if (a >= 0) begin
      sel[RG_PROG] = 1'b1;
      off          = ADDR_W'(a);
    end else if (a == -1) begin
      sel[RG_DATA] = 1'b1;
    end else if (a == -2) begin
      sel[RG_PORT] = 1'b1;
    end else if (a >= TLO) begin
      sel[RG_TIMER] = 1'b1;
      off           = ADDR_W'(a - TLO);
    end else if (a < VLO) begin
      sel[RG_VPARAM] = 1'b1;
      off            = ADDR_W'(a - PLO);
    end else if (a < BLO) begin
      sel[RG_VRAM] = 1'b1;
      off          = ADDR_W'(a - VLO);
    end else if (a <= BHI) begin
      sel[RG_BLOCK] = 1'b1;
      off           = ADDR_W'(a - BLO);
    end else begin
      sel[RG_UNUSED] = 1'b1;
    end
  end

endmodule

// File: rtl/mmio_stream_cell.sv
module mmio_stream_cell
  import mmio_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_port,
  input  logic          sel_data,
  input  logic          rd,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          in_valid,
  input  logic          out_ack,
  output logic [DW-1:0] port_q,
  output logic          in_req,
  output logic          out_req,
  output logic [DW-1:0] out_data,
  output logic          data_ready
);

  stream_st_t st;
  logic       start_in;
  logic       start_out;
  logic       port_wr;
  logic       data_access;

  assign data_access = sel_data & (rd | wr);
  assign start_in    = (st == SC_IDLE) & sel_data & rd;
  assign start_out   = (st == SC_IDLE) & sel_data & wr & ~rd;
  assign port_wr     = sel_port & wr & ~rd;

  always_comb begin
    if (!data_access) data_ready = 1'b1;
    else begin
      unique case (st)
        SC_WAIT_IN:  data_ready = in_valid;
        SC_WAIT_OUT: data_ready = out_ack;
        default:     data_ready = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= SC_IDLE;
      port_q   <= '0;
      in_req   <= 1'b0;
      out_req  <= 1'b0;
      out_data <= '0;
    end else begin
      in_req  <= 1'b0;
      out_req <= 1'b0;
      if (port_wr) port_q <= wdata;
      unique case (st)
        SC_IDLE: begin
          if (start_in) begin
            st     <= SC_WAIT_IN;
            in_req <= 1'b1;
          end else if (start_out) begin
            st       <= SC_WAIT_OUT;
            out_req  <= 1'b1;
            out_data <= wdata;
          end
        end
        SC_WAIT_IN:  if (in_valid) st <= SC_IDLE;
        SC_WAIT_OUT: if (out_ack)  st <= SC_IDLE;
        default:     st <= SC_IDLE;
      endcase
    end
  end

  assert_in_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_req |=> !in_req);
  assert_in_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_req |-> $past(sel_data && rd));
  assert_out_payload_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_req |-> ($past(sel_data && wr) && out_data == $past(wdata)));
  assert_one_dir_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_req && out_req));
  assert_no_retrigger_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_req || out_req) |=> !(in_req || out_req));

endmodule

// File: rtl/mmio_bridge.sv
module mmio_bridge
  import mmio_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CELL_W = 16,
  parameter int VID_W  = 8,
  parameter int VID_H  = 4,
  parameter int VID_C  = 2,
  parameter int PTR_S  = 1,
  parameter int TIMERS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [CELL_W-1:0] cpu_wdata,
  output logic [CELL_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic [7:0]        rgn_sel,
  output logic [ADDR_W-1:0] rgn_off,
  output logic              ext_rd,
  output logic              ext_wr,
  output logic [CELL_W-1:0] ext_wdata,
  input  logic [CELL_W-1:0] ext_rdata,
  output logic              in_req,
  input  logic              in_valid,
  input  logic [CELL_W-1:0] in_data,
  output logic              out_req,
  output logic [CELL_W-1:0] out_data,
  input  logic              out_ack,
  output logic [CELL_W-1:0] io_port
);

  logic [RGN_N-1:0]  sel;
  logic [ADDR_W-1:0] off;
  logic              ext_hit;
  logic              data_ready;
  logic [CELL_W-1:0] port_q;
  logic [CELL_W-1:0] param_val;

  mmio_region_decode #(
    .ADDR_W(ADDR_W), .VID_W(VID_W), .VID_H(VID_H), .VID_C(VID_C),
    .PTR_S(PTR_S), .TIMERS(TIMERS)
  ) u_dec (
    .addr(cpu_addr),
    .sel (sel),
    .off (off)
  );

  mmio_stream_cell #(.DW(CELL_W)) u_stream (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_port  (sel[RG_PORT]),
    .sel_data  (sel[RG_DATA]),
    .rd        (cpu_rd),
    .wr        (cpu_wr),
    .wdata     (cpu_wdata),
    .in_valid  (in_valid),
    .out_ack   (out_ack),
    .port_q    (port_q),
    .in_req    (in_req),
    .out_req   (out_req),
    .out_data  (out_data),
    .data_ready(data_ready)
  );

  assign ext_hit   = sel[RG_PROG] | sel[RG_VRAM] | sel[RG_BLOCK] | sel[RG_TIMER];
  assign ext_rd    = ext_hit & cpu_rd;
  assign ext_wr    = ext_hit & cpu_wr & ~cpu_rd;
  assign ext_wdata = cpu_wdata;
  assign rgn_sel   = sel;
  assign rgn_off   = off;
  assign io_port   = port_q;
  assign cpu_ready = data_ready;

  always_comb begin
    unique case (off[1:0])
      2'd0:    param_val = CELL_W'(VID_W);
      2'd1:    param_val = CELL_W'(VID_H);
      default: param_val = CELL_W'(VID_C);
    endcase
  end

  always_comb begin
    cpu_rdata = '0;
    if (ext_hit)              cpu_rdata = ext_rdata;
    else if (sel[RG_VPARAM])  cpu_rdata = param_val;
    else if (sel[RG_PORT])    cpu_rdata = port_q;
    else if (sel[RG_DATA])    cpu_rdata = in_data;
  end

  assert_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(rgn_sel));
  assert_param_ro_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rgn_sel[RG_VPARAM] |-> !ext_wr && !ext_rd);
  assert_unused_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rgn_sel[RG_UNUSED] |-> (!ext_wr && !ext_rd && cpu_rdata == '0));
  assert_nondata_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rgn_sel[RG_DATA] |-> cpu_ready);

endmodule

// File: tb/tb_mmio_bridge.sv
`timescale 1ns/1ps
module tb_mmio_bridge;

  localparam int W = 8, H = 4, C = 2, T = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'd0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [15:0] cpu_wdata = 16'd0;
  logic [15:0] cpu_rdata;
  logic        cpu_ready;
  logic [7:0]  rgn_sel;
  logic [15:0] rgn_off;
  logic        ext_rd, ext_wr;
  logic [15:0] ext_wdata;
  logic [15:0] ext_rdata;
  logic        in_req, in_valid = 1'b0;
  logic [15:0] in_data = 16'd0;
  logic        out_req;
  logic [15:0] out_data;
  logic        out_ack = 1'b0;
  logic [15:0] io_port;

  int compared = 0;
  int mismatched = 0;

  always #5 clk = ~clk;

  assign ext_rdata = cpu_addr ^ 16'h5A5A;

  mmio_bridge dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .rgn_sel(rgn_sel), .rgn_off(rgn_off), .ext_rd(ext_rd), .ext_wr(ext_wr),
    .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .in_req(in_req),
    .in_valid(in_valid), .in_data(in_data), .out_req(out_req), .out_data(out_data),
    .out_ack(out_ack), .io_port(io_port)
  );

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Independent model of the region map: returns bit index and offset.
  function automatic void model_region(input int a, output int idx, output int off);
    int pix_first, blk_first, tmr_first;
    pix_first = -32768 + 3;
    blk_first = pix_first + W * H * C;
    tmr_first = -3 - 3 * T + 1;
    off = 0;
    if (a >= 0)                         begin idx = 0; off = a; end
    else if (a == -1)                   idx = 6;
    else if (a == -2)                   idx = 5;
    else if (a >= tmr_first && a <= -3) begin idx = 4; off = a - tmr_first; end
    else if (a <= -32766)               begin idx = 1; off = a + 32768; end
    else if (a < blk_first)             begin idx = 2; off = a - pix_first; end
    else if (a < blk_first + 4)         begin idx = 3; off = a - blk_first; end
    else                                idx = 7;
  endfunction

  // Per-clock reference comparison of the decode path.
  always @(negedge clk) begin
    if (rst_n) begin
      int idx, off;
      bit is_ext;
      model_region(int'($signed(cpu_addr)), idx, off);
      is_ext = (idx == 0 || idx == 2 || idx == 3 || idx == 4);
      chk("R10 select", int'(rgn_sel), 1 << idx);
      chk("R10 offset", int'(rgn_off), off & 16'hFFFF);
      chk("R6 ext_rd", int'(ext_rd), int'(is_ext && cpu_rd));
      chk("R6 ext_wr", int'(ext_wr), int'(is_ext && cpu_wr && !cpu_rd));
      if (idx != 6) chk("R10 ready", int'(cpu_ready), 1);
    end
  end

  task automatic rd_cell(input int a, input int exp, input string req);
    @(posedge clk); #1;
    cpu_addr = 16'(a); cpu_rd = 1'b1;
    @(negedge clk);
    chk(req, int'(cpu_rdata), exp);
    @(posedge clk); #1;
    cpu_rd = 1'b0;
  endtask

  task automatic wr_cell(input int a, input int d);
    @(posedge clk); #1;
    cpu_addr = 16'(a); cpu_wdata = 16'(d); cpu_wr = 1'b1;
    @(posedge clk); #1;
    cpu_wr = 1'b0;
  endtask

  task automatic stream_in(input int lat, input int d, input int port);
    @(posedge clk); #1;
    cpu_addr = 16'hFFFF; cpu_rd = 1'b1;
    @(negedge clk);
    chk("R8 ready low at present", int'(cpu_ready), 0);
    chk("R8 no req yet", int'(in_req), 0);
    @(posedge clk); #1;
    if (lat == 0) begin in_valid = 1'b1; in_data = 16'(d); end
    @(negedge clk);
    chk("R8 in_req pulse", int'(in_req), 1);
    chk("R7 io_port", int'(io_port), port);
    for (int i = 0; i < lat; i++) begin
      chk("R8 stall", int'(cpu_ready), 0);
      @(posedge clk); #1;
      if (i == lat - 1) begin in_valid = 1'b1; in_data = 16'(d); end
      @(negedge clk);
      chk("R11 single in_req", int'(in_req), 0);
      chk("R11 no out_req", int'(out_req), 0);
    end
    chk("R8 ready on valid", int'(cpu_ready), 1);
    chk("R8 rdata", int'(cpu_rdata), d);
    @(posedge clk); #1;
    cpu_rd = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    chk("R11 no extra in_req", int'(in_req), 0);
  endtask

  task automatic stream_out(input int lat, input int d, input int port);
    @(posedge clk); #1;
    cpu_addr = 16'hFFFF; cpu_wdata = 16'(d); cpu_wr = 1'b1;
    @(negedge clk);
    chk("R9 ready low at present", int'(cpu_ready), 0);
    @(posedge clk); #1;
    if (lat == 0) out_ack = 1'b1;
    @(negedge clk);
    chk("R9 out_req pulse", int'(out_req), 1);
    chk("R9 out_data", int'(out_data), d);
    chk("R7 io_port", int'(io_port), port);
    for (int i = 0; i < lat; i++) begin
      chk("R9 stall", int'(cpu_ready), 0);
      @(posedge clk); #1;
      if (i == lat - 1) out_ack = 1'b1;
      @(negedge clk);
      chk("R11 single out_req", int'(out_req), 0);
      chk("R11 no in_req", int'(in_req), 0);
    end
    chk("R9 ready on ack", int'(cpu_ready), 1);
    @(posedge clk); #1;
    cpu_wr = 1'b0; out_ack = 1'b0;
    @(negedge clk);
    chk("R11 no extra out_req", int'(out_req), 0);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R7 reset port", int'(io_port), 0);
    chk("R8 reset in_req", int'(in_req), 0);
    chk("R9 reset out_req", int'(out_req), 0);
    rd_cell(-2, 0, "R7 port reads 0");
    // R1 program edges
    rd_cell(0, 16'h5A5A, "R1 first program cell");
    rd_cell(32767, (32767 ^ 16'h5A5A), "R1 last program cell");
    wr_cell(1234, 77);
    // R2 parameters, writes ignored
    rd_cell(-32768, W, "R2 width");
    rd_cell(-32767, H, "R2 height");
    rd_cell(-32766, C, "R2 depth");
    wr_cell(-32768, 999);
    wr_cell(-32766, 555);
    rd_cell(-32768, W, "R2 width after write");
    rd_cell(-32766, C, "R2 depth after write");
    // R3 pixel ends
    rd_cell(-32765, (16'h8003 ^ 16'h5A5A), "R3 first pixel");
    rd_cell(-32702, (16'h8042 ^ 16'h5A5A), "R3 last pixel");
    // R4 block cells
    for (int k = 0; k < 4; k++)
      rd_cell(-32701 + k, ((-32701 + k) & 16'hFFFF) ^ 16'h5A5A, "R4 block cell");
    wr_cell(-32698, 3);
    // R6 gap
    rd_cell(-32697, 0, "R6 gap low end");
    rd_cell(-9, 0, "R6 gap high end");
    wr_cell(-100, 4321);
    rd_cell(-100, 0, "R6 gap after write");
    // R5 timers
    rd_cell(-8, (16'hFFF8 ^ 16'h5A5A), "R5 first timer cell");
    rd_cell(-3, (16'hFFFD ^ 16'h5A5A), "R5 last timer cell");
    wr_cell(-5, 12);
    // streams on console port
    stream_in(0, 16'h1234, 0);
    stream_out(0, 16'h00AB, 0);
    // R7 select another port
    wr_cell(-2, 5);
    rd_cell(-2, 5, "R7 port readback");
    stream_in(3, 16'hBEEF, 5);
    stream_out(4, 16'hCAFE, 5);
    stream_in(1, 16'h0042, 5);
    wr_cell(-2, 0);
    rd_cell(-2, 0, "R7 port back to 0");
    stream_out(2, 16'h7777, 0);
    repeat (2) @(posedge clk);
    summary();
  end

endmodule